// File: doc/BRIEF.md
# Serial Key Unlocker for a Hidden Timekeeper

This block sits on the control side of a byte-wide static RAM and hides a 64-bit timekeeper register image behind ordinary memory traffic. Each qualified bus cycle reaches it as a one-clock strobe with a write flag and the level of data bit 0. While it is locked every cycle goes to memory. Software opens it by issuing one read and then 64 writes whose bit 0 spells a fixed key. These writes still land in memory.

Once the key has matched, the block takes over the next 64 strobes and inhibits memory during them. A read strobe returns one bit of a snapshot of the timekeeper, captured at the moment of unlock. A write strobe shifts one bit into an assembly byte. Each completed register byte is committed to the write image with a one-clock strobe. The timekeeper can abort a transfer through an active-low reset input, unless the reset-mask bit in the image is set.

The sequencer has four named states. ST_IDLE is the disarmed state. ST_MATCH compares key bits. ST_STALL is entered after a mismatch. ST_XFER moves data. The transitions are as follows:
- Arm: a read in ST_IDLE or ST_STALL goes to ST_MATCH.
- Restart: a read in ST_MATCH clears the pointer.
- Advance: a matching write in ST_MATCH moves the pointer on.
- Miss: a mismatching write goes from ST_MATCH to ST_STALL.
- Unlock: the 64th matching write goes from ST_MATCH to ST_XFER.
- Done: the 64th transfer strobe goes from ST_XFER to ST_IDLE.
- Abort: an unmasked low on the reset input goes from ST_XFER to ST_IDLE.

Top module: `phantom_unlock`

## Requirements
- R1: After reset the block is in ST_IDLE. In this state mem_inhibit is 0, commit_stb is 0 and wr_image is all zeros.
- R2: A read strobe in any state other than ST_XFER enters ST_MATCH with the key pointer at 0. A read during matching therefore restarts the key from its first bit, and a read after a mismatch re-arms matching.
- R3: The key is the byte sequence C5, 3A, A3, 5C, C5, 3A, A3, 5C, with each byte sent least significant bit first. Key bit n is bit (n mod 8) of byte n/8. Each write in ST_MATCH compares cyc_dq0 with the key bit at the pointer and advances the pointer on a match.
- R4: A mismatching key write freezes matching. All later writes are ignored, including ones that carry the continuing key bits, until the next read.
- R5: mem_inhibit is 0 for every strobe outside a transfer, including all 64 key writes.
- R6: After the 64th key bit matches, mem_inhibit is 1 for exactly the next 64 strobes. Transfer step k addresses image bit k, which is bit k mod 8 of register k/8, so the order runs from register 0 bit 0 to register 7 bit 7.
- R7: During a read strobe of a transfer, rd_bit carries the bit of tk_image that was sampled at the clock of the 64th key write. Later changes on tk_image do not affect it.
- R8: A write strobe at bit 7 of a register gives a one-clock commit_stb on the next clock. With it, commit_reg holds the register number and the register's byte of wr_image is updated. The other bytes of wr_image are unchanged.
- R9: A byte commit carries the written bits. A position in that byte that was read instead of written takes its snapshot value. If bit 7 of a register is read, that register is not committed.
- R10: After the 64th transfer strobe the block returns to ST_IDLE. Writes alone, even a complete key, do not re-arm it; a read is needed first.
- R11: During a transfer, ext_rst_n low with the reset-mask bit at 0 returns the block to ST_IDLE with no commit, and the partial byte is discarded. The reset-mask bit is image bit 36, which is register 4 bit 4 of the snapshot. With the mask bit at 1, ext_rst_n is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cyc_stb | input | 1 | One-clock strobe per qualified bus cycle |
| cyc_wr | input | 1 | 1 for a write cycle, 0 for a read cycle |
| cyc_dq0 | input | 1 | Level of data bit 0 during the cycle |
| ext_rst_n | input | 1 | Active-low transfer abort request |
| tk_image | input | 64 | Current timekeeper register image |
| mem_inhibit | output | 1 | Blocks the memory array for the current strobe |
| rd_bit | output | 1 | Bit to drive onto data bit 0 on a transfer read |
| wr_image | output | 64 | Image of committed register bytes |
| commit_stb | output | 1 | One-clock pulse when a register byte is committed |
| commit_reg | output | 3 | Register number of the last commit |

## Verification
On every cycle, the assertions check the shape of the state machine. Unlock is entered only from the last matching key write. A read outside a transfer re-arms the pointer at 0, and writes leave ST_STALL unchanged. An unmasked abort always reaches ST_IDLE. A commit follows only a write at bit 7 of a transfer, and wr_image never changes without a commit. The bench scenarios cover what needs whole sequences. These are the exact key value and its bit order, freezing after a mismatch, the snapshot staying unchanged while tk_image moves, the contents of mixed read/write bytes, and the mask-dependent abort.

// File: rtl/phx_pkg.sv
package phx_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_MATCH = 2'd1,
        ST_STALL = 2'd2,
        ST_XFER  = 2'd3
    } phx_state_t;

endpackage

// File: rtl/phx_seq.sv
module phx_seq
    import phx_pkg::*;
#(
    parameter int KEY_LEN = 64,
    parameter int XFER_LEN = 64,
    parameter logic [KEY_LEN-1:0] KEY = {2{32'h5CA33AC5}},
    localparam int PTR_W = $clog2(KEY_LEN),
    localparam int CNT_W = $clog2(XFER_LEN)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cyc_stb,
    input  logic             cyc_wr,
    input  logic             cyc_dq0,
    input  logic             abort_req,
    output phx_state_t       state,
    output logic [CNT_W-1:0] xfer_idx,
    output logic             unlock,
    output logic             step,
    output logic             mem_inhibit
);

    phx_state_t       nxt;
    logic [PTR_W-1:0] ptr, ptr_n;
    logic [CNT_W-1:0] idx_n;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            ptr      <= '0;
            xfer_idx <= '0;
        end else begin
            state    <= nxt;
            ptr      <= ptr_n;
            xfer_idx <= idx_n;
        end
    end

    // transitions
    always_comb begin
        nxt    = state;
        ptr_n  = ptr;
        idx_n  = xfer_idx;
        unlock = 1'b0;
        step   = 1'b0;
        unique case (state)
            ST_IDLE, ST_STALL: begin
                if (cyc_stb && !cyc_wr) begin
                    nxt   = ST_MATCH;
                    ptr_n = '0;
                end
            end
            ST_MATCH: begin
                if (cyc_stb) begin
                    if (!cyc_wr) begin
                        ptr_n = '0;
                    end else if (cyc_dq0 == KEY[ptr]) begin
                        if (ptr == PTR_W'(KEY_LEN-1)) begin
                            nxt    = ST_XFER;
                            unlock = 1'b1;
                            idx_n  = '0;
                        end else begin
                            ptr_n = ptr + 1'b1;
                        end
                    end else begin
                        nxt = ST_STALL;
                    end
                end
            end
            ST_XFER: begin
                if (abort_req) begin
                    nxt = ST_IDLE;
                end else if (cyc_stb) begin
                    step = 1'b1;
                    if (xfer_idx == CNT_W'(XFER_LEN-1)) nxt = ST_IDLE;
                    else idx_n = xfer_idx + 1'b1;
                end
            end
            default: nxt = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        mem_inhibit = (state == ST_XFER);
    end

    // R6
    unlock_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_XFER && $past(state) != ST_XFER) |->
            $past(state == ST_MATCH && cyc_stb && cyc_wr && ptr == PTR_W'(KEY_LEN-1)));

    // R2
    rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_stb && !cyc_wr && state != ST_XFER) |=> (state == ST_MATCH && ptr == '0));

    // R4
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STALL && cyc_stb && cyc_wr) |=> (state == ST_STALL));

    // R11
    abort_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_XFER && abort_req) |=> (state == ST_IDLE));

endmodule

// File: rtl/phx_xfer.sv
module phx_xfer #(
    parameter int IMG_W = 64,
    parameter int BYTE_W = 8,
    parameter int MASK_POS = 36,
    localparam int IDX_W = $clog2(IMG_W),
    localparam int BIT_W = $clog2(BYTE_W),
    localparam int REG_W = IDX_W - BIT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             unlock,
    input  logic             step,
    input  logic             step_wr,
    input  logic             step_dq0,
    input  logic [IDX_W-1:0] idx,
    input  logic [IMG_W-1:0] tk_image,
    output logic             rd_bit,
    output logic             mask_bit,
    output logic [IMG_W-1:0] wr_image,
    output logic             commit_stb,
    output logic [REG_W-1:0] commit_reg
);

    logic [IMG_W-1:0]  snap;
    logic [BYTE_W-1:0] asm_byte;
    logic [BIT_W-1:0]  bit_pos;
    logic [REG_W-1:0]  reg_sel;

    assign bit_pos  = idx[BIT_W-1:0];
    assign reg_sel  = idx[IDX_W-1:BIT_W];
    assign rd_bit   = snap[idx];
    assign mask_bit = snap[MASK_POS];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            snap       <= '0;
            asm_byte   <= '0;
            wr_image   <= '0;
            commit_stb <= 1'b0;
            commit_reg <= '0;
        end else begin
            commit_stb <= 1'b0;
            if (unlock) snap <= tk_image;
            if (step) begin
                asm_byte[bit_pos] <= step_wr ? step_dq0 : snap[idx];
                if (step_wr && bit_pos == BIT_W'(BYTE_W-1)) begin
                    commit_stb <= 1'b1;
                    commit_reg <= reg_sel;
                    wr_image[reg_sel*BYTE_W +: BYTE_W] <= {step_dq0, asm_byte[BYTE_W-2:0]};
                end
            end
        end
    end

    // R8
    commit_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        commit_stb |-> $past(step && step_wr && bit_pos == BIT_W'(BYTE_W-1)));

    // R8
    image_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !commit_stb |-> $stable(wr_image));

endmodule

// File: rtl/phantom_unlock.sv
module phantom_unlock
    import phx_pkg::*;
#(
    parameter int IMG_W = 64,
    parameter int BYTE_W = 8,
    parameter int KEY_LEN = 64,
    parameter logic [KEY_LEN-1:0] KEY = {2{32'h5CA33AC5}},
    parameter int MASK_POS = 36,
    localparam int IDX_W = $clog2(IMG_W),
    localparam int REG_W = IDX_W - $clog2(BYTE_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cyc_stb,
    input  logic             cyc_wr,
    input  logic             cyc_dq0,
    input  logic             ext_rst_n,
    input  logic [IMG_W-1:0] tk_image,
    output logic             mem_inhibit,
    output logic             rd_bit,
    output logic [IMG_W-1:0] wr_image,
    output logic             commit_stb,
    output logic [REG_W-1:0] commit_reg
);

    phx_state_t       state;
    logic [IDX_W-1:0] xfer_idx;
    logic             unlock, step, mask_bit, abort_req;

    assign abort_req = !ext_rst_n && !mask_bit;

    phx_seq #(
        .KEY_LEN (KEY_LEN),
        .XFER_LEN(IMG_W),
        .KEY     (KEY)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .cyc_stb    (cyc_stb),
        .cyc_wr     (cyc_wr),
        .cyc_dq0    (cyc_dq0),
        .abort_req  (abort_req),
        .state      (state),
        .xfer_idx   (xfer_idx),
        .unlock     (unlock),
        .step       (step),
        .mem_inhibit(mem_inhibit)
    );

    phx_xfer #(
        .IMG_W   (IMG_W),
        .BYTE_W  (BYTE_W),
        .MASK_POS(MASK_POS)
    ) u_xfer (
        .clk       (clk),
        .rst_n     (rst_n),
        .unlock    (unlock),
        .step      (step),
        .step_wr   (cyc_wr),
        .step_dq0  (cyc_dq0),
        .idx       (xfer_idx),
        .tk_image  (tk_image),
        .rd_bit    (rd_bit),
        .mask_bit  (mask_bit),
        .wr_image  (wr_image),
        .commit_stb(commit_stb),
        .commit_reg(commit_reg)
    );

    // R11
    abort_nocommit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_XFER && abort_req) |=> !commit_stb);

    // R5
    commit_in_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        commit_stb |-> $past(mem_inhibit));

endmodule

// File: tb/phantom_unlock_test.sv
module phantom_unlock_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cyc_stb = 1'b0, cyc_wr = 1'b0, cyc_dq0 = 1'b0;
    logic        ext_rst_n = 1'b1;
    logic [63:0] tk_image = '0;
    logic        mem_inhibit, rd_bit, commit_stb;
    logic [63:0] wr_image;
    logic [2:0]  commit_reg;

    int checks = 0;
    int failures = 0;
    logic        l_inh, l_rb, l_cs;
    logic [2:0]  l_cr;
    logic [63:0] exp_img = '0;

    always #5 clk = ~clk;

    phantom_unlock uut (
        .clk(clk), .rst_n(rst_n), .cyc_stb(cyc_stb), .cyc_wr(cyc_wr),
        .cyc_dq0(cyc_dq0), .ext_rst_n(ext_rst_n), .tk_image(tk_image),
        .mem_inhibit(mem_inhibit), .rd_bit(rd_bit), .wr_image(wr_image),
        .commit_stb(commit_stb), .commit_reg(commit_reg)
    );

    // {image, mode (1 = write), write data}
    localparam logic [191:0] VEC [4] = '{
        {64'h2199_0715_0433_5812, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0523_1108_0345_5927},
        {64'h9812_0323_0111_4400, 64'h0000_0000_0000_0000, 64'h0000_0000_0000_0000},
        {64'h5566_7788_99AA_BBCC, 64'hFF00_FF00_FF00_FF00, 64'h3C00_C300_8100_7E00},
        {64'hF0E1_D2C3_B4A5_9687, 64'h00FF_F0F0_0F0F_AA55, 64'h1234_5678_9ABC_DEF0}
    };

    function automatic logic kbit(int n);
        logic [7:0] b;
        case ((n / 8) % 4)
            0: b = 8'hC5;
            1: b = 8'h3A;
            2: b = 8'hA3;
            default: b = 8'h5C;
        endcase
        return b[n % 8];
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic cyc(input logic wr, input logic dq);
        @(negedge clk);
        cyc_stb = 1'b1; cyc_wr = wr; cyc_dq0 = dq;
        #1;
        l_inh = mem_inhibit; l_rb = rd_bit;
        @(negedge clk);
        cyc_stb = 1'b0;
        l_cs = commit_stb; l_cr = commit_reg;
    endtask

    task automatic unlock_seq();
        bit bad = 0;
        cyc(1'b0, 1'b0);
        if (l_inh) bad = 1;
        for (int n = 0; n < 64; n++) begin
            cyc(1'b1, kbit(n));
            if (l_inh) bad = 1;
        end
        chk(!bad, "R5 key cycles not inhibited", {63'd0, bad}, 64'd0);
    endtask

    task automatic drain(input int n);
        for (int k = 0; k < n; k++) cyc(1'b0, 1'b0);
    endtask

    initial begin
        #2_000_000;
        failures++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1
        chk(mem_inhibit == 0 && commit_stb == 0 && wr_image == 0, "R1 reset state",
            {wr_image[61:0], mem_inhibit, commit_stb}, 64'd0);
        rst_n = 1'b1;
        cyc(1'b1, 1'b1);
        chk(l_inh == 0, "R1 idle write goes to memory", {63'd0, l_inh}, 64'd0);

        // table walk: R3 R6 R7 R8 R9 R10
        for (int r = 0; r < 4; r++) begin
            logic [63:0] img, mode, data;
            logic [7:0]  eb;
            img = VEC[r][191:128]; mode = VEC[r][127:64]; data = VEC[r][63:0];
            tk_image = img;
            unlock_seq();
            tk_image = ~img;
            for (int i = 0; i < 64; i++) begin
                cyc(mode[i], data[i]);
                chk(l_inh == 1, "R6 transfer inhibits memory", {63'd0, l_inh}, 64'd1);
                if (!mode[i]) chk(l_rb == img[i], "R7 snapshot read bit", {63'd0, l_rb}, {63'd0, img[i]});
                eb[i % 8] = mode[i] ? data[i] : img[i];
                if (i % 8 == 7) begin
                    if (mode[i]) begin
                        chk(l_cs == 1 && l_cr == 3'(i / 8), "R8 commit strobe and register",
                            {60'd0, l_cs, l_cr}, {60'd0, 1'b1, 3'(i / 8)});
                        exp_img[(i / 8) * 8 +: 8] = eb;
                    end else begin
                        chk(l_cs == 0, "R9 read at bit 7 gives no commit", {63'd0, l_cs}, 64'd0);
                    end
                end
            end
            chk(wr_image == exp_img, "R9 committed image", wr_image, exp_img);
            cyc(1'b1, 1'b0);
            chk(l_inh == 0, "R10 idle after 64 transfers", {63'd0, l_inh}, 64'd0);
        end

        // R10: full key by writes alone does not re-arm
        for (int n = 0; n < 64; n++) cyc(1'b1, kbit(n));
        cyc(1'b1, 1'b0);
        chk(l_inh == 0, "R10 key without read stays locked", {63'd0, l_inh}, 64'd0);

        // R4: mismatch freezes, continuing key ignored
        cyc(1'b0, 1'b0);
        for (int n = 0; n < 10; n++) cyc(1'b1, kbit(n));
        cyc(1'b1, ~kbit(10));
        for (int n = 10; n < 64; n++) cyc(1'b1, kbit(n));
        cyc(1'b0, 1'b0);
        chk(l_inh == 0, "R4 frozen after mismatch", {63'd0, l_inh}, 64'd0);
        // R2: that read re-armed matching
        for (int n = 0; n < 64; n++) cyc(1'b1, kbit(n));
        cyc(1'b0, 1'b0);
        chk(l_inh == 1, "R2 read after stall re-arms", {63'd0, l_inh}, 64'd1);
        drain(63);

        // R2: read mid-key restarts from bit 0
        cyc(1'b0, 1'b0);
        for (int n = 0; n < 20; n++) cyc(1'b1, kbit(n));
        cyc(1'b0, 1'b0);
        for (int n = 20; n < 64; n++) cyc(1'b1, kbit(n));
        cyc(1'b1, 1'b0);
        chk(l_inh == 0, "R2 read restarts pointer", {63'd0, l_inh}, 64'd0);
        cyc(1'b0, 1'b0);
        for (int n = 0; n < 64; n++) cyc(1'b1, kbit(n));
        cyc(1'b0, 1'b0);
        chk(l_inh == 1, "R3 full key from bit 0 unlocks", {63'd0, l_inh}, 64'd1);
        drain(63);

        // R11: unmasked abort (register 4 bit 4 = 0)
        tk_image = 64'h0123_4567_89AB_CDEF;
        unlock_seq();
        for (int n = 0; n < 3; n++) cyc(1'b1, 1'b1);
        @(negedge clk); ext_rst_n = 1'b0;
        @(negedge clk); ext_rst_n = 1'b1;
        for (int n = 0; n < 5; n++) cyc(1'b1, 1'b1);
        chk(l_inh == 0 && l_cs == 0, "R11 abort ends transfer",
            {62'd0, l_inh, l_cs}, 64'd0);
        chk(wr_image == exp_img, "R11 abort leaves image", wr_image, exp_img);

        // R11: masked (register 4 bit 4 = 1) ignores the reset input
        tk_image = 64'h0123_4577_89AB_CDEF;
        unlock_seq();
        @(negedge clk); ext_rst_n = 1'b0;
        @(negedge clk); ext_rst_n = 1'b1;
        for (int n = 0; n < 8; n++) cyc(1'b1, n[0] ^ n[2] ? 1'b0 : 1'b1);
        exp_img[7:0] = 8'hA5;
        chk(l_inh == 1 && l_cs == 1 && l_cr == 3'd0, "R11 masked reset ignored",
            {61'd0, l_inh, l_cs, l_cr == 3'd0}, 64'd7);
        chk(wr_image == exp_img, "R8 byte 0 only updated", wr_image, exp_img);
        drain(56);
        cyc(1'b1, 1'b0);
        chk(l_inh == 0, "R10 idle after masked transfer", {63'd0, l_inh}, 64'd0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule